// File: doc/BRIEF.md
# Memory Pattern Fill and Verify Engine

This block walks an inclusive window of word addresses, chosen by software, and either stamps a known test pattern into every word of it, reads every word back and compares it against that pattern, or does both in one job. A fourth job type clears the window to zero. Four pattern pairs are available. Each pair is built from one hex nibble and its bitwise complement. Even word addresses receive the nibble replicated across the word, and odd word addresses receive the complement. This lets a quick memory test catch stuck bits and coupling between neighbouring words.

Software first sets the job type, the pattern pair and the window bounds. It then pulses the start input. While the job runs the engine raises `busy`. When the last access has completed it drops `busy` and raises `done`, and `done` stays high until the next accepted start. The memory side is a single-word request channel with a valid/ready handshake. Read data comes back on a separate response strobe. During read-back the engine captures the address of the first miscompare and keeps a saturating count of miscompares.

The controller is a five-state machine:
- `ST_IDLE` is the state after reset.
- `ST_WRITE` issues writes.
- `ST_RD_ISSUE` issues a read.
- `ST_RD_WAIT` waits for read data.
- `ST_DONE` marks a finished job.

Its transitions are as follows:
- An accepted start in `ST_IDLE` or `ST_DONE` goes to `ST_WRITE` for the fill, fill-and-check and clear jobs. It goes to `ST_RD_ISSUE` for the check job. It goes straight to `ST_DONE` when the upper bound is below the lower bound.
- `ST_WRITE` repeats until the write to the upper bound is accepted. It then goes to `ST_RD_ISSUE` (fill-and-check job, with the address reloaded to the lower bound) or to `ST_DONE`.
- `ST_RD_ISSUE` goes to `ST_RD_WAIT` when the read is accepted.
- `ST_RD_WAIT` goes back to `ST_RD_ISSUE` on each response, or to `ST_DONE` on the response for the upper bound.

Top module: `patfill_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req_valid`, `err_seen` and `err_count` are all 0.
- R2: Pattern select 0, 1, 2 and 3 choose the nibble pairs 0/F, A/5, 3/C and 6/9. An even word address gets the first nibble replicated across the whole word, and an odd address gets the second nibble.
- R3: Job type 0 (fill) writes every address from `cfg_lo_addr` to `cfg_hi_addr` inclusive exactly once, in ascending order. It writes nothing outside that window and issues no reads.
- R4: Job type 1 (check) reads every window address once. `err_count` counts the words whose data differs from the R2 pattern. `err_first_addr` holds the lowest miscompared address, and `err_seen` is 1 if any word differed.
- R5: Job type 2 (fill and check) first performs the R3 fill over the window and then the R4 check over the same window.
- R6: Job type 3 (clear) writes all-zero data to every window address. It uses no pattern and issues no reads.
- R7: `err_count` saturates at 2^CW-1 and never decreases during a job.
- R8: A request held with `mem_req_ready` low keeps its valid, address, write flag and write data unchanged until it is accepted.
- R9: `done` rises only after the final access has completed: the last write accepted, or the last read's response received. `busy` and `done` are never high together, and `done` holds until the next accepted start.
- R10: A start pulse that arrives while `busy` is high has no effect on the running job.
- R11: When `cfg_hi_addr` is below `cfg_lo_addr`, a start goes directly to `done` without issuing any memory request.
- R12: An accepted start clears `err_seen`, `err_count` and `err_first_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start pulse, accepted only when not busy |
| cfg_mode | input | 2 | Job type: 0 fill, 1 check, 2 fill and check, 3 clear |
| cfg_pat_sel | input | 2 | Pattern pair select (R2) |
| cfg_lo_addr | input | AW | First word address of the window |
| cfg_hi_addr | input | AW | Last word address of the window (inclusive) |
| busy | output | 1 | Job in progress |
| done | output | 1 | Last job finished; held until the next start |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Word address of the request |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | DW | Read data |
| err_seen | output | 1 | At least one miscompare in the current job |
| err_first_addr | output | AW | Address of the first miscompare |
| err_count | output | CW | Saturating miscompare count |

## Verification
The bench targets the following corner cases:
- **One-word window.** A design with an off-by-one on the upper bound would write one word too many or too few.
- **Window ending at the top address.** An engine that stops on wrap-around would stop early or run on.
- **Inverted window.** An engine that compared bounds badly would sweep the whole memory instead of finishing at once.
- **Miscompare placement.** Miscompares are injected at the first, the last and an out-of-window address. An engine that compared against the wrong parity, counted reads outside the window, or latched the last error instead of the first would report the wrong address or count.
- **Saturation and clearing.** A run that fails every word checks that the count saturates instead of wrapping to a small number, and the next job checks that the statistics were cleared.
- **Stalls.** A throttled ready line catches requests that change before they are accepted.
- **Start while busy.** A start issued mid-job would overwrite a second window if it were wrongly honoured.

// File: rtl/patfill_pkg.sv
package patfill_pkg;

    typedef enum logic [1:0] {
        MODE_FILL       = 2'd0,
        MODE_CHECK      = 2'd1,
        MODE_FILL_CHECK = 2'd2,
        MODE_CLEAR      = 2'd3
    } pf_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_DONE
    } pf_state_e;

    localparam int NIB_W = 4;

    // Nibble used at even addresses; odd addresses take its complement.
    function automatic logic [NIB_W-1:0] pair_nibble(input logic [1:0] sel);
        logic [NIB_W-1:0] n;
        unique case (sel)
            2'd0: n = 4'h0;
            2'd1: n = 4'hA;
            2'd2: n = 4'h3;
            2'd3: n = 4'h6;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/patfill_pattern.sv
module patfill_pattern #(
    parameter int DW = 32
) (
    input  logic [1:0]    pat_sel,
    input  logic          clear,
    input  logic          odd,
    output logic [DW-1:0] word
);
    import patfill_pkg::*;

    localparam int NIBS = DW / NIB_W;

    logic [NIB_W-1:0] nib;

    always_comb begin
        nib = pair_nibble(pat_sel);
        if (odd)   nib = ~nib;
        if (clear) nib = '0;
    end

    genvar g;
    generate
        for (g = 0; g < NIBS; g++) begin : g_rep
            assign word[g*NIB_W +: NIB_W] = nib;
        end
    endgenerate

endmodule

// File: rtl/patfill_addr_walk.sv
module patfill_addr_walk #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [AW-1:0] load_hi,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            hi_q   <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            hi_q   <= load_hi;
        end else if (step) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == hi_q);

endmodule

// File: rtl/patfill_miscount.sv
module patfill_miscount #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample,
    input  logic          mismatch,
    input  logic [AW-1:0] addr,
    output logic          seen,
    output logic [AW-1:0] first_addr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen       <= 1'b0;
            first_addr <= '0;
            count      <= '0;
        end else if (clear) begin
            seen       <= 1'b0;
            first_addr <= '0;
            count      <= '0;
        end else if (sample && mismatch) begin
            if (!seen) first_addr <= addr;
            seen <= 1'b1;
            if (count != CNT_MAX) count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/patfill_engine.sv
module patfill_engine #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic [1:0]    cfg_mode,
    input  logic [1:0]    cfg_pat_sel,
    input  logic [AW-1:0] cfg_lo_addr,
    input  logic [AW-1:0] cfg_hi_addr,
    output logic          busy,
    output logic          done,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          err_seen,
    output logic [AW-1:0] err_first_addr,
    output logic [CW-1:0] err_count
);
    import patfill_pkg::*;

    pf_state_e     state_q, state_d;
    pf_mode_e      mode_q;
    logic [1:0]    pat_q;
    logic [AW-1:0] lo_q;

    logic          start_ok;
    logic          empty_win;
    logic          req_acc;
    logic          walk_load, walk_step, walk_last;
    logic [AW-1:0] walk_addr, walk_load_addr, walk_load_hi;
    logic [DW-1:0] pat_word;
    logic          rsp_take;
    logic          wr_final;

    assign start_ok  = cfg_start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign empty_win = (cfg_hi_addr < cfg_lo_addr);
    assign req_acc   = mem_req_valid && mem_req_ready;
    assign rsp_take  = (state_q == ST_RD_WAIT) && mem_rsp_valid;
    assign wr_final  = (state_q == ST_WRITE) && req_acc && walk_last;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_ok) begin
                    if (empty_win)                        state_d = ST_DONE;
                    else if (pf_mode_e'(cfg_mode) == MODE_CHECK) state_d = ST_RD_ISSUE;
                    else                                  state_d = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (wr_final)
                    state_d = (mode_q == MODE_FILL_CHECK) ? ST_RD_ISSUE : ST_DONE;
            end
            ST_RD_ISSUE: begin
                if (req_acc) state_d = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (mem_rsp_valid) state_d = walk_last ? ST_DONE : ST_RD_ISSUE;
            end
        endcase
    end

    // State and job registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_FILL;
            pat_q   <= '0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                mode_q <= pf_mode_e'(cfg_mode);
                pat_q  <= cfg_pat_sel;
                lo_q   <= cfg_lo_addr;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy          = 1'b0;
        done          = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_WRITE:    begin busy = 1'b1; mem_req_valid = 1'b1; mem_req_we = 1'b1; end
            ST_RD_ISSUE: begin busy = 1'b1; mem_req_valid = 1'b1; end
            ST_RD_WAIT:  busy = 1'b1;
            ST_DONE:     done = 1'b1;
        endcase
    end

    assign mem_req_addr  = walk_addr;
    assign mem_req_wdata = pat_word;

    assign walk_load      = start_ok || (wr_final && mode_q == MODE_FILL_CHECK);
    assign walk_load_addr = start_ok ? cfg_lo_addr : lo_q;
    assign walk_load_hi   = cfg_hi_addr;
    assign walk_step      = ((state_q == ST_WRITE) && req_acc && !walk_last) ||
                            (rsp_take && !walk_last);

    patfill_addr_walk #(.AW(AW)) walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (walk_load && start_ok ? 1'b1 : walk_load),
        .load_addr (walk_load_addr),
        .load_hi   (start_ok ? walk_load_hi : walk_hi_keep),
        .step      (walk_step),
        .addr      (walk_addr),
        .last      (walk_last)
    );

    patfill_pattern #(.DW(DW)) pat_i (
        .pat_sel (pat_q),
        .clear   (mode_q == MODE_CLEAR),
        .odd     (walk_addr[0]),
        .word    (pat_word)
    );

    patfill_miscount #(.AW(AW), .CW(CW)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start_ok),
        .sample     (rsp_take),
        .mismatch   (mem_rsp_data != pat_word),
        .addr       (walk_addr),
        .seen       (err_seen),
        .first_addr (err_first_addr),
        .count      (err_count)
    );

    // Upper bound kept for the reload between fill and check phases.
    logic [AW-1:0] walk_hi_keep;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        walk_hi_keep <= '0;
        else if (start_ok) walk_hi_keep <= cfg_hi_addr;
    end

endmodule

// File: rtl/patfill_engine_chk.sv
module patfill_engine_chk #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic          mem_req_we,
    input logic [AW-1:0] mem_req_addr,
    input logic [DW-1:0] mem_req_wdata,
    input logic [CW-1:0] err_count
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

    assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    assert_count_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || (err_count >= $past(err_count))));

endmodule

bind patfill_engine patfill_engine_chk #(.AW(AW), .DW(DW), .CW(CW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .err_count     (err_count)
);

// File: tb/patfill_engine_tb_top.sv
`timescale 1ns/1ps
module patfill_engine_tb_top;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] SENT = 16'hBEEF;
    localparam int NVEC = 8;

    // {mode, pat, lo, hi, flip(64=none), stall, exp_cnt, exp_first}
    localparam logic [33:0] VEC [0:NVEC-1] = '{
        {2'd0, 2'd0, 6'd2,  6'd9,  7'd64, 1'b0, 4'd0, 6'd0},
        {2'd0, 2'd1, 6'd0,  6'd63, 7'd64, 1'b1, 4'd0, 6'd0},
        {2'd2, 2'd2, 6'd5,  6'd12, 7'd7,  1'b1, 4'd1, 6'd7},
        {2'd2, 2'd3, 6'd10, 6'd10, 7'd64, 1'b0, 4'd0, 6'd0},
        {2'd3, 2'd2, 6'd3,  6'd20, 7'd64, 1'b1, 4'd0, 6'd0},
        {2'd1, 2'd2, 6'd5,  6'd12, 7'd12, 1'b0, 4'd1, 6'd12},
        {2'd1, 2'd1, 6'd40, 6'd47, 7'd30, 1'b1, 4'd0, 6'd0},
        {2'd2, 2'd0, 6'd62, 6'd63, 7'd63, 1'b0, 4'd1, 6'd63}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_start = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [1:0]    cfg_pat_sel = '0;
    logic [AW-1:0] cfg_lo_addr = '0;
    logic [AW-1:0] cfg_hi_addr = '0;
    logic          busy, done;
    logic          mem_req_valid, mem_req_we;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          err_seen;
    logic [AW-1:0] err_first_addr;
    logic [CW-1:0] err_count;

    logic          ready_q = 1'b1;
    logic          stall_en = 1'b0;
    logic [6:0]    flip_addr = 7'd64;
    logic          bk_en = 1'b0, bk_fill = 1'b0;
    logic [1:0]    bk_pat = '0;
    logic [AW-1:0] bk_lo = '0, bk_hi = '0;
    logic          cnt_clr = 1'b0;
    int            wr_cnt = 0, rd_cnt = 0;
    logic [DW-1:0] mem [DEPTH];

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    patfill_engine #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
        .cfg_pat_sel(cfg_pat_sel), .cfg_lo_addr(cfg_lo_addr), .cfg_hi_addr(cfg_hi_addr),
        .busy(busy), .done(done), .mem_req_valid(mem_req_valid), .mem_req_ready(ready_q),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .err_seen(err_seen),
        .err_first_addr(err_first_addr), .err_count(err_count)
    );

    function automatic logic [DW-1:0] exp_word(input logic [1:0] p, input bit clr, input int a);
        logic [3:0] n;
        case (p)
            2'd0: n = 4'h0;
            2'd1: n = 4'hA;
            2'd2: n = 4'h3;
            default: n = 4'h6;
        endcase
        if (a % 2 == 1) n = ~n;
        if (clr) n = 4'h0;
        return {4{n}};
    endfunction

    // Memory model with backdoor preload and access counters
    always @(posedge clk) begin
        if (bk_en)
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (bk_fill && i >= int'(bk_lo) && i <= int'(bk_hi)) ? exp_word(bk_pat, 1'b0, i) : SENT;
        if (cnt_clr) begin
            wr_cnt <= 0;
            rd_cnt <= 0;
        end
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && ready_q) begin
            if (mem_req_we) begin
                mem[mem_req_addr] <= mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr] ^ (({1'b0, mem_req_addr} == flip_addr) ? 16'h0001 : 16'h0000);
                rd_cnt <= rd_cnt + 1;
            end
        end
        ready_q <= stall_en ? ~ready_q : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic preload(input bit fill, input logic [1:0] p, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
        @(negedge clk);
        bk_en = 1'b1; bk_fill = fill; bk_pat = p; bk_lo = lo; bk_hi = hi; cnt_clr = 1'b1;
        @(negedge clk);
        bk_en = 1'b0; cnt_clr = 1'b0;
    endtask

    task automatic launch(input logic [1:0] m, input logic [1:0] p, input logic [AW-1:0] lo, input logic [AW-1:0] hi);
        @(negedge clk);
        cfg_mode = m; cfg_pat_sel = p; cfg_lo_addr = lo; cfg_hi_addr = hi; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        while (!done && w < 5000) begin
            @(negedge clk);
            w++;
        end
    endtask

    // Counts words differing from: pattern inside [lo,hi], sentinel outside
    function automatic int scan_bad(input logic [1:0] p, input bit clr, input int lo, input int hi);
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i >= lo && i <= hi) begin
                if (mem[i] !== exp_word(p, clr, i)) bad++;
            end else if (mem[i] !== SENT) bad++;
        end
        return bad;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !mem_req_valid, "R1", "busy/done/valid", {busy, done, mem_req_valid}, 0);
        chk(!err_seen && err_count == 0, "R1", "error stats", {err_seen, err_count}, 0);
        rst_n = 1'b1;
        preload(1'b0, 2'd0, '0, '0);

        // R11: inverted window completes with no accesses
        launch(2'd0, 2'd1, 6'd9, 6'd3);
        chk(done && !busy, "R11", "done after inverted window", {busy, done}, 1);
        repeat (3) @(negedge clk);
        chk(wr_cnt == 0 && rd_cnt == 0, "R11", "accesses", wr_cnt + rd_cnt, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] m, p;
            int lo, hi, n, ecnt, efirst;
            m = VEC[v][33:32]; p = VEC[v][31:30];
            lo = int'(VEC[v][29:24]); hi = int'(VEC[v][23:18]);
            ecnt = int'(VEC[v][9:6]); efirst = int'(VEC[v][5:0]);
            n = hi - lo + 1;
            stall_en = VEC[v][10];
            flip_addr = VEC[v][17:11];
            preload(m == 2'd1, p, VEC[v][29:24], VEC[v][23:18]);
            launch(m, p, VEC[v][29:24], VEC[v][23:18]);
            wait_done();
            // R9: at the moment done is seen every access has completed
            chk(done && !busy, "R9", $sformatf("vec%0d done", v), {busy, done}, 1);
            chk(wr_cnt == ((m == 2'd1) ? 0 : n), "R3 R6 R9", $sformatf("vec%0d writes", v), wr_cnt, (m == 2'd1) ? 0 : n);
            chk(rd_cnt == ((m == 2'd1 || m == 2'd2) ? n : 0), "R4 R5 R9", $sformatf("vec%0d reads", v), rd_cnt,
                (m == 2'd1 || m == 2'd2) ? n : 0);
            chk(scan_bad(p, m == 2'd3, lo, hi) == 0, "R2 R3 R6", $sformatf("vec%0d memory image", v),
                scan_bad(p, m == 2'd3, lo, hi), 0);
            chk(int'(err_count) == ecnt && err_seen == (ecnt != 0), "R4 R5", $sformatf("vec%0d err count", v),
                int'(err_count), ecnt);
            if (ecnt != 0)
                chk(int'(err_first_addr) == efirst, "R4", $sformatf("vec%0d first addr", v), int'(err_first_addr), efirst);
            stall_en = 1'b0;
            flip_addr = 7'd64;
        end

        // R2: explicit pair words at even/odd addresses
        preload(1'b0, 2'd0, '0, '0);
        launch(2'd1 == 2'd1 ? 2'd0 : 2'd0, 2'd3, 6'd20, 6'd21);
        wait_done();
        chk(mem[20] == 16'h6666 && mem[21] == 16'h9999, "R2", "pair 6/9 words", {mem[20], mem[21]}, 32'h66669999);

        // R10: start while busy is ignored
        preload(1'b0, 2'd0, '0, '0);
        stall_en = 1'b1;
        launch(2'd0, 2'd1, 6'd0, 6'd30);
        repeat (5) @(negedge clk);
        cfg_mode = 2'd3; cfg_lo_addr = 6'd40; cfg_hi_addr = 6'd50; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_done();
        stall_en = 1'b0;
        chk(wr_cnt == 31, "R10", "writes of first job only", wr_cnt, 31);
        chk(scan_bad(2'd1, 1'b0, 0, 30) == 0, "R10", "memory image", scan_bad(2'd1, 1'b0, 0, 30), 0);

        // R7: every word miscompares, count saturates
        preload(1'b1, 2'd0, 6'd0, 6'd19);
        launch(2'd1, 2'd1, 6'd0, 6'd19);
        wait_done();
        chk(err_count == 4'hF, "R7", "saturated count", int'(err_count), 15);
        chk(err_seen && err_first_addr == 0, "R7", "first addr", int'(err_first_addr), 0);

        // R12: next accepted start clears the statistics
        launch(2'd0, 2'd2, 6'd30, 6'd31);
        chk(busy && err_count == 0 && !err_seen, "R12", "stats cleared", {err_seen, err_count}, 0);
        wait_done();
        chk(done, "R12", "job completes", done, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule